// File: doc/BRIEF.md
# Interlaced Field Sequencer with External Resync

This block produces the vertical timing for an interlaced frame-transfer image sensor. Left alone, it free-runs from the local clock. It counts clocks within a line and lines within a field, and it alternates odd and even fields, so two fields make one frame. Each field boundary gives a one-cycle frame-transfer pulse and a one-cycle integration-start pulse. These tell the sensor to move the exposed charge into storage and to begin the next exposure.

An active-low external trigger lets the application align capture with an outside event. The trigger is synchronised and its falling edges are detected. Each such edge forces the sequencer back to the first line of an odd field, which cuts the running exposure short. Transfer and integration start are then pulsed at once, and the readout that follows is marked as coming from a shortened exposure. Normal alternation returns after one uninterrupted field.

Top module: `vfield_seq`

## Requirements
- R1: A synchronous active-high system reset puts the sequencer at clock 0 of line 0 of an odd field, with the interrupted flag low and both strobes low. An external input held high through and after reset causes no resync.
- R2: The line counter advances by one every CLKS_PER_LINE clocks. After line LINES_PER_FIELD-1 it returns to 0.
- R3: At each natural field boundary the field flag toggles (1 = odd, 0 = even). Both strobes are high for exactly that one cycle, and in that cycle the line counter reads 0.
- R4: With the external input held high, the sequencer free-runs with a field period of CLKS_PER_LINE*LINES_PER_FIELD clocks and a frame of two fields.
- R5: A falling edge on the external input takes effect three clocks after the first clock edge that samples it low. In that cycle the line is 0, the field is odd and the line timer restarts.
- R6: Both strobes pulse in the cycle a resync takes effect, whatever field was running.
- R7: A resync sets the interrupted flag. The next natural boundary clears it and moves on to an even field.
- R8: Only falling edges act. A low pulse of one clock causes a resync, holding the input low causes no further resync, and a rising edge has no effect.
- R9: Repeated resyncs within a field each restart an odd, interrupted field. The first full field after the last one is even and not interrupted.
- R10: A resync that lands in the same cycle as a natural boundary wins: the field is odd and interrupted, not even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous system reset, active high |
| ext_trig_n | input | 1 | Asynchronous resync trigger, active low, idles high |
| line_o | output | $clog2(LINES_PER_FIELD) | Current line within the field |
| field_odd_o | output | 1 | 1 during an odd field, 0 during an even field |
| xfer_stb_o | output | 1 | One-cycle frame-transfer pulse |
| integ_stb_o | output | 1 | One-cycle integration-start pulse |
| intr_rd_o | output | 1 | High while the readout comes from a shortened exposure |

## Verification
A wrong line or clock count shows at the next line boundary, because line_o steps at the wrong moment. It also moves the strobes off the line-0 cycle within one field period. A field flag or interrupted flag that does not change state is visible at the next boundary or resync, where the expected odd/even value and interrupted value no longer match. A resync-path error, such as a missing synchroniser stage, a wrong edge polarity or repeated triggering on a held level, shifts or duplicates the return to line 0. That shows within three clocks of the input change.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic {
        FLD_EVEN = 1'b0,
        FLD_ODD  = 1'b1
    } field_e;

    function automatic field_e fsq_other_field(input field_e f);
        return (f == FLD_ODD) ? FLD_EVEN : FLD_ODD;
    endfunction

endpackage

// File: rtl/fsq_edge_sync.sv
module fsq_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n_i,
    output logic fall_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } sync_t;

    sync_t st_d, st_q;
    logic [SYNC_STAGES-1:0] stage_d;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign stage_d[g] = async_n_i;
            end else begin : g_rest
                assign stage_d[g] = st_q.chain[g-1];
            end
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = stage_d;
        st_d.prev  = st_q.chain[LAST];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.chain <= '1;
            st_q.prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.prev & ~st_q.chain[LAST];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R8

endmodule

// File: rtl/fsq_line_timer.sv
module fsq_line_timer #(
    parameter int CLKS_PER_LINE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic line_end_o
);

    localparam int PIX_W = (CLKS_PER_LINE > 1) ? $clog2(CLKS_PER_LINE) : 1;
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(CLKS_PER_LINE - 1);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.pix = '0;
        end else if (st_q.pix == PIX_LAST) begin
            st_d.pix = '0;
        end else begin
            st_d.pix = st_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pix <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_end_o = (st_q.pix == PIX_LAST);

    AST_PIX_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.pix <= PIX_LAST); // R2
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (st_q.pix == '0)); // R5

endmodule

// File: rtl/fsq_field_ctrl.sv
module fsq_field_ctrl
    import fsq_pkg::*;
#(
    parameter int LINES_PER_FIELD = 10
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                line_end_i,
    input  logic                                resync_i,
    output logic [$clog2(LINES_PER_FIELD)-1:0] line_o,
    output logic                                field_odd_o,
    output logic                                xfer_stb_o,
    output logic                                integ_stb_o,
    output logic                                intr_rd_o
);

    localparam int LINE_W = $clog2(LINES_PER_FIELD);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FIELD - 1);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        field_e            field;
        logic              intr;
        logic              xfer;
        logic              integ;
    } fld_t;

    fld_t st_d, st_q;
    logic field_end;

    assign field_end = line_end_i && (st_q.line == LINE_LAST);

    always_comb begin
        st_d       = st_q;
        st_d.xfer  = 1'b0;
        st_d.integ = 1'b0;
        if (resync_i) begin
            st_d.line  = '0;
            st_d.field = FLD_ODD;
            st_d.intr  = 1'b1;
            st_d.xfer  = 1'b1;
            st_d.integ = 1'b1;
        end else if (field_end) begin
            st_d.line  = '0;
            st_d.field = fsq_other_field(st_q.field);
            st_d.intr  = 1'b0;
            st_d.xfer  = 1'b1;
            st_d.integ = 1'b1;
        end else if (line_end_i) begin
            st_d.line = st_q.line + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.line  <= '0;
            st_q.field <= FLD_ODD;
            st_q.intr  <= 1'b0;
            st_q.xfer  <= 1'b0;
            st_q.integ <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o      = st_q.line;
    assign field_odd_o = (st_q.field == FLD_ODD);
    assign xfer_stb_o  = st_q.xfer;
    assign integ_stb_o = st_q.integ;
    assign intr_rd_o   = st_q.intr;

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.line <= LINE_LAST); // R2
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!line_end_i && !resync_i) |=> $stable(st_q.line)); // R2
    AST_STB_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        st_q.xfer |-> (st_q.line == '0)); // R3
    AST_FIELD_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (field_end && !resync_i) |=> (st_q.field != $past(st_q.field))); // R3
    AST_RESYNC_ODD: assert property (@(posedge clk) disable iff (rst)
        resync_i |=> (st_q.field == FLD_ODD && st_q.intr && st_q.line == '0)); // R5
    AST_RESYNC_STB: assert property (@(posedge clk) disable iff (rst)
        resync_i |=> (st_q.xfer && st_q.integ)); // R6
    AST_INTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (field_end && !resync_i) |=> !st_q.intr); // R7

endmodule

// File: rtl/vfield_seq.sv
module vfield_seq #(
    parameter int CLKS_PER_LINE   = 16,
    parameter int LINES_PER_FIELD = 10,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                ext_trig_n,
    output logic [$clog2(LINES_PER_FIELD)-1:0] line_o,
    output logic                                field_odd_o,
    output logic                                xfer_stb_o,
    output logic                                integ_stb_o,
    output logic                                intr_rd_o
);

    logic resync;
    logic line_end;

    fsq_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst       (rst),
        .async_n_i (ext_trig_n),
        .fall_o    (resync)
    );

    fsq_line_timer #(
        .CLKS_PER_LINE(CLKS_PER_LINE)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (resync),
        .line_end_o (line_end)
    );

    fsq_field_ctrl #(
        .LINES_PER_FIELD(LINES_PER_FIELD)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .line_end_i  (line_end),
        .resync_i    (resync),
        .line_o      (line_o),
        .field_odd_o (field_odd_o),
        .xfer_stb_o  (xfer_stb_o),
        .integ_stb_o (integ_stb_o),
        .intr_rd_o   (intr_rd_o)
    );

    AST_STB_PAIRED: assert property (@(posedge clk) disable iff (rst)
        xfer_stb_o |-> (integ_stb_o && line_o == '0)); // R6

endmodule

// File: tb/vfield_seq_tb_top.sv
module vfield_seq_tb_top;

    localparam int CPL = 4;
    localparam int LPF = 5;
    localparam int LW  = $clog2(LPF);
    localparam int NV  = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_trig_n = 1'b1;
    logic [LW-1:0] line_o;
    logic          field_odd_o, xfer_stb_o, integ_stb_o, intr_rd_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vfield_seq #(
        .CLKS_PER_LINE(CPL),
        .LINES_PER_FIELD(LPF),
        .SYNC_STAGES(2)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .ext_trig_n  (ext_trig_n),
        .line_o      (line_o),
        .field_odd_o (field_odd_o),
        .xfer_stb_o  (xfer_stb_o),
        .integ_stb_o (integ_stb_o),
        .intr_rd_o   (intr_rd_o)
    );

    // {req[3:0], ext, wait[5:0], line[2:0], odd, intr, stb}
    localparam logic [16:0] VEC [NV] = '{
        {4'd2,  1'b1, 6'd5,  3'd1, 1'b1, 1'b0, 1'b0}, // R2 mid-field line
        {4'd2,  1'b1, 6'd14, 3'd4, 1'b1, 1'b0, 1'b0}, // R2 last line
        {4'd3,  1'b1, 6'd1,  3'd0, 1'b0, 1'b0, 1'b1}, // R3 boundary to even
        {4'd3,  1'b1, 6'd1,  3'd0, 1'b0, 1'b0, 1'b0}, // R3 strobe one cycle
        {4'd4,  1'b1, 6'd19, 3'd0, 1'b1, 1'b0, 1'b1}, // R4 frame complete
        {4'd4,  1'b1, 6'd10, 3'd2, 1'b1, 1'b0, 1'b0}, // R4 free-running
        {4'd5,  1'b0, 6'd2,  3'd3, 1'b1, 1'b0, 1'b0}, // R5 not yet
        {4'd5,  1'b0, 6'd1,  3'd0, 1'b1, 1'b1, 1'b1}, // R5 resync lands
        {4'd8,  1'b0, 6'd1,  3'd0, 1'b1, 1'b1, 1'b0}, // R8 held low
        {4'd8,  1'b0, 6'd10, 3'd2, 1'b1, 1'b1, 1'b0}, // R8 held low long
        {4'd8,  1'b1, 6'd5,  3'd4, 1'b1, 1'b1, 1'b0}, // R8 rising edge
        {4'd7,  1'b1, 6'd4,  3'd0, 1'b0, 1'b0, 1'b1}, // R7 cleared, even
        {4'd7,  1'b1, 6'd8,  3'd2, 1'b0, 1'b0, 1'b0}, // R7 even runs
        {4'd6,  1'b0, 6'd3,  3'd0, 1'b1, 1'b1, 1'b1}, // R6 resync from even
        {4'd9,  1'b1, 6'd4,  3'd1, 1'b1, 1'b1, 1'b0}, // R9
        {4'd9,  1'b0, 6'd3,  3'd0, 1'b1, 1'b1, 1'b1}, // R9 second resync
        {4'd9,  1'b1, 6'd20, 3'd0, 1'b0, 1'b0, 1'b1}, // R9 full field, even
        {4'd8,  1'b0, 6'd1,  3'd0, 1'b0, 1'b0, 1'b0}, // R8 short pulse
        {4'd8,  1'b1, 6'd2,  3'd0, 1'b1, 1'b1, 1'b1}, // R8 one-clock pulse acts
        {4'd10, 1'b1, 6'd17, 3'd4, 1'b1, 1'b1, 1'b0}, // R10
        {4'd10, 1'b0, 6'd3,  3'd0, 1'b1, 1'b1, 1'b1}, // R10 coincident
        {4'd10, 1'b1, 6'd20, 3'd0, 1'b0, 1'b0, 1'b1}  // R10 then even
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input int req, input logic [LW-1:0] e_line,
                         input logic e_odd, input logic e_intr, input logic e_stb);
        checks++;
        if (line_o !== e_line || field_odd_o !== e_odd || intr_rd_o !== e_intr ||
            xfer_stb_o !== e_stb || integ_stb_o !== e_stb) begin
            failures++;
            $display("FAIL R%0d: got line=%0d odd=%0b intr=%0b xfer=%0b integ=%0b exp line=%0d odd=%0b intr=%0b stb=%0b",
                     req, line_o, field_odd_o, intr_rd_o, xfer_stb_o, integ_stb_o,
                     e_line, e_odd, e_intr, e_stb);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        check(1, '0, 1'b1, 1'b0, 1'b0); // R1 reset state

        for (int i = 0; i < NV; i++) begin
            ext_trig_n = VEC[i][12];
            step(int'(VEC[i][11:6]));
            check(int'(VEC[i][16:13]), VEC[i][5:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R1: reset mid-run clears an interrupted state
        ext_trig_n = 1'b0;
        step(3);
        check(5, '0, 1'b1, 1'b1, 1'b1); // R5
        ext_trig_n = 1'b1;
        step(5);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        check(1, '0, 1'b1, 1'b0, 1'b0); // R1
        step(5);
        check(1, LW'(1), 1'b1, 1'b0, 1'b0); // R1 no spurious resync

        // R4: long idle-high run, one full frame later back to odd top
        step(35);
        check(4, '0, 1'b1, 1'b0, 1'b1); // R4

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule